// File: doc/BRIEF.md
# Vector Store Decode and Address Unit

This block sits in the load/store pipe of a processor core. It handles the floating-point/vector store-register instructions. It accepts one 32-bit instruction word at a time, together with the value of the general base register named by the instruction, the current stack-pointer value and a flag that says whether floating-point/vector instructions are enabled. From these it produces a memory write request: the byte address, the byte count and the vector register index that supplies the data. It also produces a base-register update when the addressing mode needs one.

Three addressing forms are understood. The scaled unsigned-offset form adds an unsigned 12-bit immediate, multiplied by the access size, to the base and leaves the base unchanged. The pre-index form adds a signed 9-bit immediate to the base, uses that sum as the access address and writes it back to the base. The post-index form uses the unmodified base as the access address and writes back base plus the signed 9-bit immediate. Access sizes are 1, 2, 4, 8 and 16 bytes. An instruction that is not a legal store raises an undefined-instruction flag. A disabled floating-point unit raises a trap flag. A misaligned stack-pointer base raises an alignment flag. In each of these three cases no request and no writeback is issued.

The write request leaves through a registered valid/ready port and stays unchanged until the memory side takes it. The writeback and the fault flags are single-cycle pulses.

Top module: `vecStoreAgu`

## Requirements
- R1: After reset, reqValid, wbValid, fpTrap, spAlignFault and undefFault are 0, and instrReady is 1.
- R2: An instruction is legal only when word bits 29:27 are 111 and bit 26 is 1, and its mode bits match one of three patterns. Bits 25:24 = 01 is the unsigned-offset form. Bits 25:24 = 00, bit 21 = 0 and bits 11:10 = 01 is post-index. Bits 25:24 = 00, bit 21 = 0 and bits 11:10 = 11 is pre-index. Any other word makes undefFault pulse and issues no request and no writeback.
- R3: The size field is bits 31:30 and the operation field is bits 23:22. Operation 00 with size 0, 1, 2 or 3 gives reqBytes of 1, 2, 4 or 8. Operation 10 with size 0 gives 16. Operation 01 or 11, or operation 10 with a nonzero size, is undefined.
- R4: In the unsigned-offset form, reqAddr equals base + (bits 21:10 zero-extended and shifted left by log2 of the byte count), computed modulo 2^64, and no writeback is issued.
- R5: In the pre-index form, reqAddr equals base + sign-extended bits 20:12, and the same value is written back.
- R6: In the post-index form, reqAddr equals the unmodified base, and wbAddr equals base + sign-extended bits 20:12.
- R7: reqVecReg equals bits 4:0. When bits 9:5 equal 31, the base is spVal and a writeback has wbToSp = 1. Otherwise the base is baseVal, and a writeback has wbToSp = 0 with wbRegIdx equal to bits 9:5.
- R8: When bits 9:5 equal 31 and spVal bits 3:0 are nonzero, a legal instruction with fpEnable = 1 makes spAlignFault pulse and issues no request and no writeback. A misaligned baseVal raises no fault.
- R9: A legal instruction with fpEnable = 0 makes fpTrap pulse and issues no request and no writeback. The faults take priority in the order undefFault, then fpTrap, then spAlignFault, and at most one fault flag is set at a time.
- R10: While reqValid is 1 and reqReady is 0, reqValid, reqAddr, reqBytes and reqVecReg hold their values, and instrReady is 0. An instrValid presented while instrReady is 0 has no effect.
- R11: All results of an instruction accepted at a clock edge appear right after that edge. wbValid and the fault flags are high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is present |
| instrReady | output | 1 | Block can take an instruction this cycle |
| instrWord | input | 32 | Instruction word |
| baseVal | input | 64 | Value of the general base register named by bits 9:5 |
| spVal | input | 64 | Stack-pointer value |
| fpEnable | input | 1 | Floating-point/vector instructions enabled |
| reqValid | output | 1 | Store request valid |
| reqReady | input | 1 | Memory side takes the request |
| reqAddr | output | 64 | Store byte address |
| reqBytes | output | 5 | Number of bytes to write |
| reqVecReg | output | 5 | Vector register that supplies the data |
| wbValid | output | 1 | Base writeback pulse |
| wbToSp | output | 1 | Writeback targets the stack pointer |
| wbRegIdx | output | 5 | General register index for the writeback |
| wbAddr | output | 64 | Updated base value |
| fpTrap | output | 1 | Floating-point disabled trap pulse |
| spAlignFault | output | 1 | Stack-pointer misalignment pulse |
| undefFault | output | 1 | Undefined-instruction pulse |

## Verification
Every result of an accepted instruction comes from a single register stage, so request fields, writeback and fault flags are all due in the cycle right after the accepting edge. The bench drives each word on a falling edge and lets one rising edge pass. It samples at the next falling edge, which is exactly that cycle. Pulse widths and the hold behaviour of a stalled request are checked one falling edge later. The sweep covers every size and operation combination against every addressing form, both base sources and boundary immediates, and compares against addresses computed arithmetically in the bench.

// File: rtl/vsaPkg.sv
package vsaPkg;

  typedef enum logic [1:0] {
    MODE_UOFF = 2'd0,
    MODE_POST = 2'd1,
    MODE_PRE  = 2'd2,
    MODE_NONE = 2'd3
  } addrMode_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic       capture;   // load request and writeback registers
    logic       useSp;     // base comes from the stack pointer
    addrMode_e  mode;
    logic [2:0] sizeLog2;  // log2 of access bytes
  } vsaStrobe_t;

  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned MAX_LOG2 = 4;
  localparam int unsigned BYTES_W  = MAX_LOG2 + 1;
  localparam logic [REG_IDX_W-1:0] SP_IDX = '1;

endpackage

// File: rtl/vsaDecode.sv
module vsaDecode
  import vsaPkg::*;
(
  input  logic [INSTR_W-1:0]   instrWord,
  output logic                 legal,
  output addrMode_e            mode,
  output logic [2:0]           sizeLog2,
  output logic [REG_IDX_W-1:0] baseIdx
);

  logic       familyOk;
  logic       sizeOk;
  logic       modeOk;
  logic [1:0] szField;
  logic [1:0] opField;
  logic [1:0] formField;
  logic [1:0] idxField;

  assign szField   = instrWord[31:30];
  assign opField   = instrWord[23:22];
  assign formField = instrWord[25:24];
  assign idxField  = instrWord[11:10];
  assign baseIdx   = instrWord[9:5];
  assign familyOk  = (instrWord[29:27] == 3'b111) && instrWord[26];

  always_comb begin
    sizeOk   = 1'b0;
    sizeLog2 = 3'd0;
    unique case (opField)
      2'b00: begin
        sizeOk   = 1'b1;
        sizeLog2 = {1'b0, szField};
      end
      2'b10: begin
        sizeOk   = (szField == 2'b00);
        sizeLog2 = 3'(MAX_LOG2);
      end
      default: begin
        sizeOk   = 1'b0;
        sizeLog2 = 3'd0;
      end
    endcase
  end

  always_comb begin
    mode   = MODE_NONE;
    modeOk = 1'b0;
    if (formField == 2'b01) begin
      mode   = MODE_UOFF;
      modeOk = 1'b1;
    end else if (formField == 2'b00 && !instrWord[21]) begin
      if (idxField == 2'b01) begin
        mode   = MODE_POST;
        modeOk = 1'b1;
      end else if (idxField == 2'b11) begin
        mode   = MODE_PRE;
        modeOk = 1'b1;
      end
    end
  end

  assign legal = familyOk && sizeOk && modeOk;

endmodule

// File: rtl/vsaControl.sv
module vsaControl
  import vsaPkg::*;
#(
  parameter int unsigned SP_ALIGN_BITS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     instrValid,
  output logic                     instrReady,
  input  logic [INSTR_W-1:0]       instrWord,
  input  logic                     fpEnable,
  input  logic [SP_ALIGN_BITS-1:0] spLowBits,
  input  logic                     reqReady,
  output vsaStrobe_t               strobe,
  output logic                     reqValid,
  output logic                     wbValid,
  output logic                     wbToSp,
  output logic                     fpTrap,
  output logic                     spAlignFault,
  output logic                     undefFault
);

  logic                 legal;
  addrMode_e            mode;
  logic [2:0]           sizeLog2;
  logic [REG_IDX_W-1:0] baseIdx;
  logic                 accept;
  logic                 baseIsSp;
  logic                 spMisaligned;
  logic                 trapNow;
  logic                 alignNow;
  logic                 issue;
  logic                 wantsWb;

  vsaDecode u_decode (
    .instrWord (instrWord),
    .legal     (legal),
    .mode      (mode),
    .sizeLog2  (sizeLog2),
    .baseIdx   (baseIdx)
  );

  assign instrReady   = !reqValid || reqReady;
  assign accept       = instrValid && instrReady;
  assign baseIsSp     = (baseIdx == SP_IDX);
  assign spMisaligned = |spLowBits;
  assign trapNow      = accept && legal && !fpEnable;
  assign alignNow     = accept && legal && fpEnable && baseIsSp && spMisaligned;
  assign issue        = accept && legal && fpEnable && !(baseIsSp && spMisaligned);
  assign wantsWb      = (mode == MODE_POST) || (mode == MODE_PRE);

  always_comb begin
    strobe.capture  = issue;
    strobe.useSp    = baseIsSp;
    strobe.mode     = mode;
    strobe.sizeLog2 = sizeLog2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid     <= 1'b0;
      wbValid      <= 1'b0;
      wbToSp       <= 1'b0;
      fpTrap       <= 1'b0;
      spAlignFault <= 1'b0;
      undefFault   <= 1'b0;
    end else begin
      if (issue)         reqValid <= 1'b1;
      else if (reqReady) reqValid <= 1'b0;
      wbValid      <= issue && wantsWb;
      wbToSp       <= issue && wantsWb && baseIsSp;
      fpTrap       <= trapNow;
      spAlignFault <= alignNow;
      undefFault   <= accept && !legal;
    end
  end

  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid);

  a_r9_one_fault: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fpTrap, spAlignFault, undefFault}));

  a_r9_fault_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    (fpTrap || spAlignFault || undefFault) |-> !wbValid);

  a_r11_wb_with_req: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> reqValid);

  a_r11_wb_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid || reqValid);

  a_r4_uoff_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.mode == MODE_UOFF |=> !wbValid);

endmodule

// File: rtl/vsaDatapath.sv
module vsaDatapath
  import vsaPkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [ADDR_W-1:0]    spVal,
  input  vsaStrobe_t           strobe,
  output logic [ADDR_W-1:0]    reqAddr,
  output logic [BYTES_W-1:0]   reqBytes,
  output logic [REG_IDX_W-1:0] reqVecReg,
  output logic [REG_IDX_W-1:0] wbRegIdx,
  output logic [ADDR_W-1:0]    wbAddr
);

  localparam int unsigned UIMM_W = 12;
  localparam int unsigned SIMM_W = 9;

  logic [UIMM_W-1:0] uImm;
  logic [SIMM_W-1:0] sImm;
  logic [ADDR_W-1:0] baseSel;
  logic [ADDR_W-1:0] uOffset;
  logic [ADDR_W-1:0] sOffset;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] accessAddr;

  assign uImm    = instrWord[21:10];
  assign sImm    = instrWord[20:12];
  assign baseSel = strobe.useSp ? spVal : baseVal;
  assign uOffset = {{(ADDR_W-UIMM_W){1'b0}}, uImm} << strobe.sizeLog2;
  assign sOffset = {{(ADDR_W-SIMM_W){sImm[SIMM_W-1]}}, sImm};
  assign offset  = (strobe.mode == MODE_UOFF) ? uOffset : sOffset;
  assign sum     = baseSel + offset;

  always_comb begin
    unique case (strobe.mode)
      MODE_POST: accessAddr = baseSel;
      default:   accessAddr = sum;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr   <= '0;
      reqBytes  <= '0;
      reqVecReg <= '0;
      wbRegIdx  <= '0;
      wbAddr    <= '0;
    end else if (strobe.capture) begin
      reqAddr   <= accessAddr;
      reqBytes  <= BYTES_W'(1) << strobe.sizeLog2;
      reqVecReg <= instrWord[4:0];
      wbRegIdx  <= instrWord[9:5];
      wbAddr    <= sum;
    end
  end

  a_r3_bytes_legal: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> $onehot(reqBytes));

  a_r6_post_base: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.mode == MODE_POST |=> reqAddr == $past(baseSel));

  a_r5_pre_same: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.mode == MODE_PRE |=> reqAddr == wbAddr);

endmodule

// File: rtl/vecStoreAgu.sv
module vecStoreAgu
  import vsaPkg::*;
#(
  parameter int unsigned ADDR_W        = 64,
  parameter int unsigned SP_ALIGN_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrValid,
  output logic                 instrReady,
  input  logic [31:0]          instrWord,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [ADDR_W-1:0]    spVal,
  input  logic                 fpEnable,
  output logic                 reqValid,
  input  logic                 reqReady,
  output logic [ADDR_W-1:0]    reqAddr,
  output logic [4:0]           reqBytes,
  output logic [4:0]           reqVecReg,
  output logic                 wbValid,
  output logic                 wbToSp,
  output logic [4:0]           wbRegIdx,
  output logic [ADDR_W-1:0]    wbAddr,
  output logic                 fpTrap,
  output logic                 spAlignFault,
  output logic                 undefFault
);

  vsaStrobe_t strobe;

  vsaControl #(.SP_ALIGN_BITS(SP_ALIGN_BITS)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .instrValid   (instrValid),
    .instrReady   (instrReady),
    .instrWord    (instrWord),
    .fpEnable     (fpEnable),
    .spLowBits    (spVal[SP_ALIGN_BITS-1:0]),
    .reqReady     (reqReady),
    .strobe       (strobe),
    .reqValid     (reqValid),
    .wbValid      (wbValid),
    .wbToSp       (wbToSp),
    .fpTrap       (fpTrap),
    .spAlignFault (spAlignFault),
    .undefFault   (undefFault)
  );

  vsaDatapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .baseVal   (baseVal),
    .spVal     (spVal),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqBytes  (reqBytes),
    .reqVecReg (reqVecReg),
    .wbRegIdx  (wbRegIdx),
    .wbAddr    (wbAddr)
  );

  a_r10_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> $stable(reqAddr) && $stable(reqBytes) && $stable(reqVecReg));

  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |-> !instrReady);

endmodule

// File: tb/vecStoreAgu_bench.sv
module vecStoreAgu_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instrValid;
  logic        instrReady;
  logic [31:0] instrWord;
  logic [63:0] baseVal;
  logic [63:0] spVal;
  logic        fpEnable;
  logic        reqValid;
  logic        reqReady;
  logic [63:0] reqAddr;
  logic [4:0]  reqBytes;
  logic [4:0]  reqVecReg;
  logic        wbValid;
  logic        wbToSp;
  logic [4:0]  wbRegIdx;
  logic [63:0] wbAddr;
  logic        fpTrap;
  logic        spAlignFault;
  logic        undefFault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vecStoreAgu u_vecStoreAgu (
    .clk (clk), .rstN (rstN), .instrValid (instrValid), .instrReady (instrReady),
    .instrWord (instrWord), .baseVal (baseVal), .spVal (spVal), .fpEnable (fpEnable),
    .reqValid (reqValid), .reqReady (reqReady), .reqAddr (reqAddr), .reqBytes (reqBytes),
    .reqVecReg (reqVecReg), .wbValid (wbValid), .wbToSp (wbToSp), .wbRegIdx (wbRegIdx),
    .wbAddr (wbAddr), .fpTrap (fpTrap), .spAlignFault (spAlignFault), .undefFault (undefFault)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode: 0 uoff, 1 post, 2 pre, 3 form 10, 4 bit21 set, 5 index bits 00
  function automatic logic [31:0] buildWord(input logic [1:0] sz, input logic [1:0] opc,
      input int mode, input logic [11:0] imm, input logic [4:0] rn, input logic [4:0] rt);
    case (mode)
      0:       return {sz, 3'b111, 1'b1, 2'b01, opc, imm, rn, rt};
      1:       return {sz, 3'b111, 1'b1, 2'b00, opc, 1'b0, imm[8:0], 2'b01, rn, rt};
      2:       return {sz, 3'b111, 1'b1, 2'b00, opc, 1'b0, imm[8:0], 2'b11, rn, rt};
      3:       return {sz, 3'b111, 1'b1, 2'b10, opc, imm, rn, rt};
      4:       return {sz, 3'b111, 1'b1, 2'b00, opc, 1'b1, imm[8:0], 2'b01, rn, rt};
      default: return {sz, 3'b111, 1'b1, 2'b00, opc, 1'b0, imm[8:0], 2'b00, rn, rt};
    endcase
  endfunction

  task automatic runOne(input logic [1:0] sz, input logic [1:0] opc, input int mode,
      input logic [11:0] imm, input logic [4:0] rn, input logic [4:0] rt,
      input logic [63:0] b, input logic [63:0] sp, input bit fe, input bit famOk);
    bit legalSz, legal, eUndef, eTrap, eAlign, eReq, eWb;
    int lg;
    logic [63:0] baseSel, off, sum, eAddr;
    logic [2:0] eFlags, aFlags;
    string mTag;
    legalSz = (opc == 2'b00) || (opc == 2'b10 && sz == 2'b00);
    lg      = (opc == 2'b10) ? 4 : int'(sz);
    legal   = legalSz && (mode <= 2) && famOk;
    eUndef  = !legal;
    eTrap   = legal && !fe;
    eAlign  = legal && fe && rn == 5'd31 && sp[3:0] != 4'd0;
    eReq    = legal && fe && !eAlign;
    eWb     = eReq && mode != 0;
    baseSel = (rn == 5'd31) ? sp : b;
    off     = (mode == 0) ? ({52'd0, imm} << lg) : {{55{imm[8]}}, imm[8:0]};
    sum     = baseSel + off;
    eAddr   = (mode == 1) ? baseSel : sum;
    mTag    = (mode == 0) ? "R4" : (mode == 1) ? "R6" : "R5";
    instrWord  = buildWord(sz, opc, mode, imm, rn, rt) ^ (famOk ? 32'd0 : 32'h0800_0000);
    baseVal    = b;
    spVal      = sp;
    fpEnable   = fe;
    instrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
    eFlags = {eUndef, eTrap, eAlign};
    aFlags = {undefFault, fpTrap, spAlignFault};
    chk(aFlags == eFlags, eUndef ? "R2" : (eTrap ? "R9" : "R8"), 64'(aFlags), 64'(eFlags));
    chk(reqValid == eReq, "R11", 64'(reqValid), 64'(eReq));
    chk(wbValid == eWb, "R11", 64'(wbValid), 64'(eWb));
    if (eReq) begin
      chk(reqAddr == eAddr, mTag, reqAddr, eAddr);
      chk(reqBytes == 5'(1 << lg), "R3", 64'(reqBytes), 64'(1 << lg));
      chk(reqVecReg == rt, "R7", 64'(reqVecReg), 64'(rt));
    end
    if (eWb) begin
      chk(wbAddr == sum, mTag, wbAddr, sum);
      chk(wbToSp == (rn == 5'd31), "R7", 64'(wbToSp), 64'(rn == 5'd31));
      if (rn != 5'd31) chk(wbRegIdx == rn, "R7", 64'(wbRegIdx), 64'(rn));
    end
  endtask

  localparam logic [63:0] GPR_BASE = 64'h0000_1234_5678_9AB0;
  localparam logic [63:0] SP_OK    = 64'h0000_7FFF_FFF0_0000;

  initial begin
    rstN = 1'b0; instrValid = 1'b0; instrWord = '0; baseVal = '0; spVal = '0;
    fpEnable = 1'b1; reqReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(reqValid == 1'b0 && wbValid == 1'b0, "R1", 64'({reqValid, wbValid}), 64'd0);
    chk({fpTrap, spAlignFault, undefFault} == 3'b000, "R1",
        64'({fpTrap, spAlignFault, undefFault}), 64'd0);
    chk(instrReady == 1'b1, "R1", 64'(instrReady), 64'd1);
    rstN = 1'b1;
    @(negedge clk);

    // Main sweep: every size class x legal form x base source x boundary immediates
    for (int cls = 0; cls < 5; cls++) begin
      for (int m = 0; m < 3; m++) begin
        for (int r = 0; r < 2; r++) begin
          for (int k = 0; k < 3; k++) begin
            logic [11:0] imm;
            logic [1:0] sz, opc;
            sz  = (cls == 4) ? 2'b00 : 2'(cls);
            opc = (cls == 4) ? 2'b10 : 2'b00;
            if (m == 0) imm = (k == 0) ? 12'd0 : (k == 1) ? 12'd1 : 12'hFFF;
            else        imm = (k == 0) ? 12'd0 : (k == 1) ? 12'h0FF : 12'h100;
            runOne(sz, opc, m, imm, (r == 0) ? 5'd5 : 5'd31, 5'((cls * 7 + m * 3 + k) % 32),
                   GPR_BASE, SP_OK, 1'b1, 1'b1);
          end
        end
      end
    end
    // Address wrap on the pre-index form
    runOne(2'b11, 2'b00, 2, 12'h0FF, 5'd9, 5'd2, 64'hFFFF_FFFF_FFFF_FFF0, SP_OK, 1'b1, 1'b1);

    // R3: all size / operation combinations
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 4; s++)
        runOne(2'(s), 2'(o), 0, 12'd3, 5'd4, 5'd17, GPR_BASE, SP_OK, 1'b1, 1'b1);

    // R2: malformed forms and wrong family bits
    for (int m = 3; m < 6; m++)
      runOne(2'b10, 2'b00, m, 12'd8, 5'd4, 5'd1, GPR_BASE, SP_OK, 1'b1, 1'b1);
    runOne(2'b10, 2'b00, 0, 12'd8, 5'd4, 5'd1, GPR_BASE, SP_OK, 1'b1, 1'b0);

    // R8: misaligned SP base faults; misaligned general base does not
    runOne(2'b11, 2'b00, 2, 12'd16, 5'd31, 5'd3, GPR_BASE, SP_OK | 64'h8, 1'b1, 1'b1);
    runOne(2'b00, 2'b00, 1, 12'd1, 5'd31, 5'd3, GPR_BASE, SP_OK | 64'h1, 1'b1, 1'b1);
    runOne(2'b11, 2'b00, 2, 12'd16, 5'd6, 5'd3, GPR_BASE | 64'h7, SP_OK | 64'h8, 1'b1, 1'b1);

    // R9: trap, and priority among faults
    runOne(2'b01, 2'b00, 0, 12'd2, 5'd6, 5'd3, GPR_BASE, SP_OK, 1'b0, 1'b1);
    runOne(2'b01, 2'b00, 1, 12'd2, 5'd31, 5'd3, GPR_BASE, SP_OK | 64'h4, 1'b0, 1'b1);
    runOne(2'b01, 2'b01, 0, 12'd2, 5'd31, 5'd3, GPR_BASE, SP_OK | 64'h4, 1'b0, 1'b1);

    // R11: pulses last one cycle
    runOne(2'b10, 2'b00, 1, 12'd4, 5'd7, 5'd8, GPR_BASE, SP_OK, 1'b1, 1'b1);
    @(negedge clk);
    chk(wbValid == 1'b0 && reqValid == 1'b0, "R11", 64'({wbValid, reqValid}), 64'd0);
    runOne(2'b10, 2'b11, 0, 12'd4, 5'd7, 5'd8, GPR_BASE, SP_OK, 1'b1, 1'b1);
    @(negedge clk);
    chk(undefFault == 1'b0, "R11", 64'(undefFault), 64'd0);

    // R10: stall holds the request and ignores a new instruction
    reqReady = 1'b0;
    runOne(2'b11, 2'b00, 2, 12'h020, 5'd10, 5'd21, GPR_BASE, SP_OK, 1'b1, 1'b1);
    chk(instrReady == 1'b0, "R10", 64'(instrReady), 64'd0);
    instrWord  = buildWord(2'b00, 2'b00, 1, 12'h001, 5'd12, 5'd30);
    baseVal    = 64'h55;
    instrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(reqValid == 1'b1, "R10", 64'(reqValid), 64'd1);
    chk(reqAddr == GPR_BASE + 64'h20, "R10", reqAddr, GPR_BASE + 64'h20);
    chk(reqBytes == 5'd8 && reqVecReg == 5'd21, "R10", 64'({reqBytes, reqVecReg}), 64'({5'd8, 5'd21}));
    chk(wbValid == 1'b0, "R10", 64'(wbValid), 64'd0);
    instrValid = 1'b0;
    reqReady   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(reqValid == 1'b0, "R10", 64'(reqValid), 64'd0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule